// File: doc/BRIEF.md
# Plotter Command Pulse Driver

This block sits between a host-side device register and the six discrete command lines of a pen plotter mechanism. The host presents a six-bit command with exactly one bit set. The bit selects one of six moves: carriage left, carriage right, drum up, drum down, pen raise or pen lower. The block then drives the matching line low for a programmed number of clock cycles. Every line rests high while idle, and no more than one line is ever low.

After the pulse, the block waits a programmed settle time for the mechanism. It then drops its busy indication, raises an interrupt request and sets an operation-complete flag in a small status word. When the host reads the status word, the interrupt and the latched flags clear. A strap input exchanges the two pen lines, which covers a harness wired the wrong way round.

The command port follows valid/ready naming, but it never applies back-pressure. `cmd_ready` is high exactly when the block is idle. A `cmd_valid` offered while `cmd_ready` is low is discarded, and the overrun flag records it. The host is expected to wait for `cmd_ready` or for the interrupt before it sends the next command. The pulse length, the settle length and the pen swap are sampled in the cycle a command is accepted.

Top module: `plot_pulse_drv`

## Requirements
- R1: While reset is held and after it is released, all six lines of `plot_n` are 1, `irq` is 0, `sts_word` is 0 and `cmd_ready` is 1.
- R2: A command is accepted at the clock edge where `cmd_valid` and `cmd_ready` are both high and `cmd_bits` has exactly one bit set. From the next cycle, the line with the same index goes low and the other five stay high. Bit and line order is 0 carriage left, 1 carriage right, 2 drum up, 3 drum down, 4 pen raise, 5 pen lower.
- R3: The selected line stays low for exactly `cfg_pulse_len` cycles, and a length of 0 is treated as 1.
- R4: Busy lasts exactly pulse plus `cfg_settle_len` cycles, starting the cycle after acceptance. The busy indication is `sts_word[0]`, and `cmd_ready` is its inverse. All lines are high during the settle part.
- R5: At the edge where busy falls, `irq` and the complete flag `sts_word[1]` both become 1. They stay 1 until a status read clears them.
- R6: An `sts_rd` pulse clears `irq`, `sts_word[1]`, `sts_word[2]` and `sts_word[3]` at the next edge. A completion or error event at that same edge takes priority over the clear.
- R7: A `cmd_valid` while busy is ignored and sets the overrun flag `sts_word[2]`. The active line and the total busy length are not affected.
- R8: A `cmd_valid` while idle with zero or more than one bit set in `cmd_bits` starts nothing and sets the bad-command flag `sts_word[3]`.
- R9: With `cfg_pen_swap` at 1, command bit 4 drives line 5 and command bit 5 drives line 4. The other lines are unaffected.
- R10: Changes to `cfg_pulse_len`, `cfg_settle_len` or `cfg_pen_swap` while busy do not alter the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| cmd_bits | input | 6 | One-hot command request |
| cfg_pulse_len | input | CNT_W | Pulse length in cycles |
| cfg_settle_len | input | CNT_W | Settle delay in cycles after the pulse |
| cfg_pen_swap | input | 1 | Strap that exchanges the pen raise and pen lower lines |
| sts_rd | input | 1 | Status read strobe, which clears the latched flags |
| sts_word | output | 4 | {bad command, overrun, complete, busy} |
| irq | output | 1 | Interrupt request |
| plot_n | output | 6 | Active-low plotter command lines |

## Verification
Several internal faults show up at the lines themselves. A wrong state register or a stale command register leaves a line low outside its pulse or drives two lines low together, and this is visible in the first cycle after acceptance. A counter that loads or decrements wrongly changes the measured low time or busy time by at least one cycle, and this is only seen when the command completes. Faults in the flag logic appear at the next status read, as an interrupt that does not clear or an error bit that is missing.

// File: rtl/plot_pkg.sv
package plot_pkg;
  localparam int NLINE = 6;
  localparam int STS_W = 4;

  localparam int LN_PEN_UP   = 4;
  localparam int LN_PEN_DOWN = 5;

  localparam int STS_BUSY = 0;
  localparam int STS_DONE = 1;
  localparam int STS_OVR  = 2;
  localparam int STS_BAD  = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/plot_cmd_decode.sv
module plot_cmd_decode
  import plot_pkg::*;
#(
  parameter int N = NLINE
) (
  input  logic [N-1:0] cmd,
  input  logic         swap,
  output logic         onehot,
  output logic [N-1:0] line_sel
);
  assign onehot = (cmd != '0) && ((cmd & (cmd - 1'b1)) == '0);

  for (genvar i = 0; i < N; i++) begin : g_map
    if (i == LN_PEN_UP) begin : g_up
      assign line_sel[i] = swap ? cmd[LN_PEN_DOWN] : cmd[i];
    end else if (i == LN_PEN_DOWN) begin : g_dn
      assign line_sel[i] = swap ? cmd[LN_PEN_UP] : cmd[i];
    end else begin : g_direct
      assign line_sel[i] = cmd[i];
    end
  end
endmodule

// File: rtl/plot_pulse_timer.sv
module plot_pulse_timer
  import plot_pkg::*;
#(
  parameter int N     = NLINE,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N-1:0]     line_sel,
  input  logic [CNT_W-1:0] pulse_len,
  input  logic [CNT_W-1:0] settle_len,
  output logic [N-1:0]     lines_n,
  output logic             busy,
  output logic             finish
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmr_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] settle_q;
  logic [CNT_W-1:0] pulse_eff;
  logic             last;

  assign pulse_eff = (pulse_len == '0) ? ONE : pulse_len;
  assign last      = (cnt == ONE);
  assign busy      = (state != ST_IDLE);
  assign finish    = ((state == ST_PULSE) && last && (settle_q == '0)) ||
                     ((state == ST_SETTLE) && last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      settle_q <= '0;
      lines_n  <= '1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_PULSE;
            cnt      <= pulse_eff;
            settle_q <= settle_len;
            lines_n  <= ~line_sel;
          end
        end
        ST_PULSE: begin
          if (last) begin
            lines_n <= '1;
            if (settle_q == '0) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_SETTLE;
              cnt   <= settle_q;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_SETTLE: begin
          if (last) state <= ST_IDLE;
          else      cnt   <= cnt - ONE;
        end
        default: begin
          state   <= ST_IDLE;
          lines_n <= '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/plot_status.sv
module plot_status (
  input  logic clk,
  input  logic rst_n,
  input  logic finish,
  input  logic ovr_evt,
  input  logic bad_evt,
  input  logic rd,
  output logic irq,
  output logic done,
  output logic ovr,
  output logic bad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      done <= 1'b0;
      ovr  <= 1'b0;
      bad  <= 1'b0;
    end else begin
      if (finish) begin
        irq  <= 1'b1;
        done <= 1'b1;
      end else if (rd) begin
        irq  <= 1'b0;
        done <= 1'b0;
      end
      if (ovr_evt)  ovr <= 1'b1;
      else if (rd)  ovr <= 1'b0;
      if (bad_evt)  bad <= 1'b1;
      else if (rd)  bad <= 1'b0;
    end
  end
endmodule

// File: rtl/plot_pulse_drv.sv
module plot_pulse_drv
  import plot_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [NLINE-1:0] cmd_bits,
  input  logic [CNT_W-1:0] cfg_pulse_len,
  input  logic [CNT_W-1:0] cfg_settle_len,
  input  logic             cfg_pen_swap,
  input  logic             sts_rd,
  output logic [STS_W-1:0] sts_word,
  output logic             irq,
  output logic [NLINE-1:0] plot_n
);
  logic             onehot;
  logic [NLINE-1:0] line_sel;
  logic             busy;
  logic             finish;
  logic             accept;
  logic             done_f, ovr_f, bad_f;

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & ~busy;

  plot_cmd_decode #(.N(NLINE)) u_dec (
    .cmd      (cmd_bits),
    .swap     (cfg_pen_swap),
    .onehot   (onehot),
    .line_sel (line_sel)
  );

  plot_pulse_timer #(.N(NLINE), .CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept & onehot),
    .line_sel   (line_sel),
    .pulse_len  (cfg_pulse_len),
    .settle_len (cfg_settle_len),
    .lines_n    (plot_n),
    .busy       (busy),
    .finish     (finish)
  );

  plot_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .finish  (finish),
    .ovr_evt (cmd_valid & busy),
    .bad_evt (accept & ~onehot),
    .rd      (sts_rd),
    .irq     (irq),
    .done    (done_f),
    .ovr     (ovr_f),
    .bad     (bad_f)
  );

  always_comb begin
    sts_word           = '0;
    sts_word[STS_BUSY] = busy;
    sts_word[STS_DONE] = done_f;
    sts_word[STS_OVR]  = ovr_f;
    sts_word[STS_BAD]  = bad_f;
  end
endmodule

// File: rtl/plot_pulse_drv_chk.sv
module plot_pulse_drv_chk
  import plot_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [NLINE-1:0] cmd_bits,
  input logic             sts_rd,
  input logic [STS_W-1:0] sts_word,
  input logic             irq,
  input logic [NLINE-1:0] plot_n
);
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~plot_n) <= 1);

  a_r4_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_word[STS_BUSY] |-> (plot_n == '1));

  a_r5_irq_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_word[STS_BUSY]) |-> (irq && sts_word[STS_DONE]));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !sts_word[STS_BUSY] && !cmd_valid) |=>
      (!irq && !sts_word[STS_DONE] && !sts_word[STS_OVR] && !sts_word[STS_BAD]));

  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (sts_word[STS_OVR] && $stable(plot_n)));

  a_r8_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && $countones(cmd_bits) != 1) |=>
      (sts_word[STS_BAD] && !sts_word[STS_BUSY]));

  a_r2_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && $countones(cmd_bits) == 1) |=>
      (sts_word[STS_BUSY] && $countones(~plot_n) == 1));
endmodule

bind plot_pulse_drv plot_pulse_drv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_bits  (cmd_bits),
  .sts_rd    (sts_rd),
  .sts_word  (sts_word),
  .irq       (irq),
  .plot_n    (plot_n)
);

// File: tb/tb_plot_pulse_drv.sv
module tb_plot_pulse_drv;
  localparam int CW = 32;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [5:0]    cmd_bits = '0;
  logic [CW-1:0] cfg_pulse_len = '0;
  logic [CW-1:0] cfg_settle_len = '0;
  logic          cfg_pen_swap = 1'b0;
  logic          sts_rd = 1'b0;
  logic [3:0]    sts_word;
  logic          irq;
  logic [5:0]    plot_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  plot_pulse_drv #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bits(cmd_bits), .cfg_pulse_len(cfg_pulse_len),
    .cfg_settle_len(cfg_settle_len), .cfg_pen_swap(cfg_pen_swap),
    .sts_rd(sts_rd), .sts_word(sts_word), .irq(irq), .plot_n(plot_n)
  );

  // {cmd[5:0], swap, pulse[7:0], settle[7:0], expected low line[5:0]}
  localparam logic [28:0] VEC [NV] = '{
    {6'b000001, 1'b0, 8'd3, 8'd2, 6'b000001},
    {6'b000010, 1'b0, 8'd1, 8'd0, 6'b000010},
    {6'b000100, 1'b0, 8'd5, 8'd1, 6'b000100},
    {6'b001000, 1'b0, 8'd2, 8'd4, 6'b001000},
    {6'b010000, 1'b0, 8'd4, 8'd0, 6'b010000},
    {6'b100000, 1'b0, 8'd2, 8'd3, 6'b100000},
    {6'b010000, 1'b1, 8'd3, 8'd1, 6'b100000},
    {6'b100000, 1'b1, 8'd2, 8'd2, 6'b010000},
    {6'b000001, 1'b1, 8'd2, 8'd1, 6'b000001},
    {6'b000100, 1'b0, 8'd0, 8'd2, 6'b000100}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] c);
    @(negedge clk);
    cmd_bits  = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
  endtask

  // Called at the first negedge after acceptance; counts until busy drops.
  task automatic measure(input logic [5:0] exp_low, output int low_n,
                         output int busy_n, output bit stray);
    low_n = 0; busy_n = 0; stray = 0;
    while (sts_word[0] && busy_n < 1000) begin
      if (plot_n != 6'h3f) low_n++;
      if (plot_n != 6'h3f && plot_n != ~exp_low) stray = 1;
      if (cmd_ready) stray = 1;
      busy_n++;
      @(negedge clk);
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int low_n, busy_n, eff;
    bit stray;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(plot_n == 6'h3f, "R1 lines in reset", 32'(plot_n), 32'h3f);
    rst_n = 1'b1;
    @(negedge clk);
    check(plot_n == 6'h3f, "R1 lines", 32'(plot_n), 32'h3f);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    check(sts_word == 4'h0, "R1 status", 32'(sts_word), 0);
    check(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);

    // Table walk: R2, R3, R4, R5, R6, R9
    for (int v = 0; v < NV; v++) begin
      logic [5:0] c, e;
      int pl, sl;
      c  = VEC[v][28:23];
      pl = int'(VEC[v][21:14]);
      sl = int'(VEC[v][13:6]);
      e  = VEC[v][5:0];
      cfg_pen_swap   = VEC[v][22];
      cfg_pulse_len  = CW'(pl);
      cfg_settle_len = CW'(sl);
      issue(c);
      check(plot_n == ~e, VEC[v][22] ? "R9 swapped line" : "R2 first pulse cycle",
            32'(plot_n), 32'(~e));
      measure(e, low_n, busy_n, stray);
      eff = (pl == 0) ? 1 : pl;
      check(low_n == eff, "R3 pulse length", 32'(low_n), 32'(eff));
      check(busy_n == eff + sl, "R4 busy length", 32'(busy_n), 32'(eff + sl));
      check(!stray, "R2 only one line, ready low while busy", 32'(stray), 0);
      check(irq && sts_word == 4'b0010, "R5 completion flags",
            32'({irq, sts_word}), 32'h12);
      status_read();
      check(!irq && sts_word == 4'h0, "R6 read clears", 32'({irq, sts_word}), 0);
    end

    // R8: bad commands while idle
    issue(6'b000000);
    check(sts_word == 4'b1000 && plot_n == 6'h3f, "R8 zero bits",
          32'({sts_word, plot_n}), 32'h23f);
    issue(6'b000011);
    check(sts_word == 4'b1000 && plot_n == 6'h3f && !irq, "R8 two bits",
          32'({sts_word, plot_n}), 32'h23f);
    status_read();
    check(sts_word == 4'h0, "R6 read clears bad flag", 32'(sts_word), 0);

    // R7 and R10: strobe during busy, config changes during busy
    cfg_pen_swap = 1'b0; cfg_pulse_len = 6; cfg_settle_len = 2;
    issue(6'b010000);
    cfg_pulse_len = 40; cfg_settle_len = 40; cfg_pen_swap = 1'b1;
    cmd_bits = 6'b000001; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(sts_word[2] == 1'b1, "R7 overrun flag", 32'(sts_word), 32'h5);
    measure(6'b010000, low_n, busy_n, stray);
    check(low_n == 5, "R10 pulse kept", 32'(low_n), 5);
    check(busy_n == 7, "R7 busy length unchanged", 32'(busy_n), 7);
    check(!stray, "R10 line unchanged by swap", 32'(stray), 0);
    check(sts_word == 4'b0110 && irq, "R7 flags at completion",
          32'({irq, sts_word}), 32'h16);
    status_read();
    check(sts_word == 4'h0 && !irq, "R6 read clears overrun",
          32'({irq, sts_word}), 0);

    // R6: completion at the same edge as a read wins
    cfg_pen_swap = 1'b0; cfg_pulse_len = 2; cfg_settle_len = 0;
    issue(6'b001000);
    @(negedge clk);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    check(irq && sts_word == 4'b0010, "R6 completion beats read",
          32'({irq, sts_word}), 32'h12);
    status_read();
    check(!irq && sts_word == 4'h0, "R6 later read clears",
          32'({irq, sts_word}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule